// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block resolves one operand specifier for a 16-bit machine with eight general registers, where register 7 serves as the program counter. A specifier is a 3-bit mode plus a 3-bit register number. When `start` is pulsed, the sequencer reads the named register and steps it up or down as the mode requires. It then fetches any extension word through the program counter and follows one level of pointer indirection if asked. Finally it pulses `done`. At that point it presents either a flag saying the operand is the register itself or a 16-bit effective address.

The program counter is handled like any other register. Immediate, absolute, PC-relative and relative-deferred operands therefore come out of the autoincrement and index modes applied to register 7. The register file and the memory both sit outside the block. The register file is reached through a combinational read port and a registered write port. The memory is reached through a word read port with a request/valid handshake.

Top module: `oprnd_ea_seq`

## Requirements
- R1: Each word fetched through register 7 as an extension word (an index base, an immediate or an absolute address) leaves register 7 two greater than the address used for that fetch.
- R2: Mode 0 reports `is_reg`=1 with `ea`=0, issues no memory read and writes no register.
- R3: Mode 1 reports the register value as `ea` and leaves the register unchanged.
- R4: Mode 2 reports the register value as `ea` and then adds the step to the register. The step is 1 for a byte operand on registers 0 to 5. Otherwise it is 2, which always covers registers 6 and 7.
- R5: Mode 4 subtracts the same step from the register first and reports the new value as `ea`.
- R6: Modes 3 and 5 step the register by 2 regardless of operand size. They read the memory word at the (post-step for mode 5, pre-step for mode 3) register value and report that word as `ea`.
- R7: Mode 6 reads a base word at the program counter, advances the program counter by 2, and reports base plus the named register's value taken after that advance. With register 7, PC at octal 22 and base octal 54, `ea` is octal 100.
- R8: Mode 7 computes the mode 6 address and then reads the word there, which becomes `ea`. With register 4 holding octal 100, base octal 14 and location octal 114 holding octal 2000, `ea` is octal 2000.
- R9: `mem_req` stays high with `mem_addr` stable until a cycle with `mem_valid` high, and only one read is outstanding at a time.
- R10: All register stepping and address sums wrap modulo 2^16.
- R11: After reset `done`, `mem_req` and `rf_wr_en` are low, and `done` is a single-cycle pulse.
- R12: The memory reads issued are exactly these, in order: none for modes 0, 1, 2 and 4; one for modes 3 and 5; one for mode 6; two for mode 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving a specifier (accepted when idle) |
| spec_mode | input | 3 | Addressing mode 0..7 |
| spec_reg | input | 3 | Register number 0..7 |
| byte_op | input | 1 | Operand is a byte |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is the register itself (valid with done) |
| ea | output | 16 | Effective address (valid with done) |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data, same cycle |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Memory read data |

## Verification
The hardest case is index mode through register 7. The write that advances the program counter must reach the register file before the sequencer reads it back to form the sum. This matters most when the memory answers with no wait states, because the window between the write and the read-back is then shortest. The stimulus sweeps every mode and register pairing for both operand sizes under memory latencies of zero, one and two cycles, and it also replays the two worked octal examples. A behavioural model predicts every memory read address in order and the full register file after each operation.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REGRD, S_PCRD, S_BASE, S_IDX, S_IND
  } seq_state_t;

  localparam logic [2:0] M_REG     = 3'd0;
  localparam logic [2:0] M_REGDEF  = 3'd1;
  localparam logic [2:0] M_AINC    = 3'd2;
  localparam logic [2:0] M_AINCDEF = 3'd3;
  localparam logic [2:0] M_ADEC    = 3'd4;
  localparam logic [2:0] M_ADECDEF = 3'd5;
  localparam logic [2:0] M_IDX     = 3'd6;
  localparam logic [2:0] M_IDXDEF  = 3'd7;
endpackage

// File: rtl/ea_step_calc.sv
module ea_step_calc #(
  parameter int DW = 16,
  parameter int RW = 3,
  parameter int PC_IDX = 7,
  parameter int SP_IDX = 6
) (
  input  logic [DW-1:0] value,
  input  logic [RW-1:0] reg_idx,
  input  logic          byte_op,
  input  logic          deferred,
  output logic [DW-1:0] inc_val,
  output logic [DW-1:0] dec_val
);
  logic          unit_step;
  logic [DW-1:0] step;

  always_comb begin
    unit_step = byte_op && !deferred &&
                (reg_idx != RW'(PC_IDX)) && (reg_idx != RW'(SP_IDX));
    step    = unit_step ? DW'(1) : DW'(2);
    inc_val = value + step;
    dec_val = value - step;
  end
endmodule

// File: rtl/ea_mem_req.sv
module ea_mem_req #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic          mem_valid,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          fire
);
  assign fire = mem_req && mem_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (issue) begin
      mem_req  <= 1'b1;
      mem_addr <= issue_addr;
    end else if (fire) begin
      mem_req  <= 1'b0;
    end
  end
endmodule

// File: rtl/oprnd_ea_seq.sv
module oprnd_ea_seq
  import ea_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3,
  parameter int PC_IDX = 7,
  parameter int SP_IDX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    spec_mode,
  input  logic [RW-1:0] spec_reg,
  input  logic          byte_op,
  output logic          done,
  output logic          is_reg,
  output logic [DW-1:0] ea,
  output logic [RW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic [RW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [RW-1:0] PC_SEL = RW'(PC_IDX);

  seq_state_t    state;
  logic [2:0]    mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic [DW-1:0] base_q;
  logic [DW-1:0] inc_val, dec_val, idx_sum, pc_next;
  logic          deferred_step;
  logic          issue, fire;
  logic [DW-1:0] issue_addr;

  assign rf_rd_idx     = (state == S_PCRD) ? PC_SEL : reg_q;
  assign deferred_step = (mode_q == M_AINCDEF) || (mode_q == M_ADECDEF);
  assign idx_sum       = base_q + rf_rd_data;
  assign pc_next       = rf_rd_data + DW'(2);

  ea_step_calc #(.DW(DW), .RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX)) u_step (
    .value   (rf_rd_data),
    .reg_idx (reg_q),
    .byte_op (byte_q),
    .deferred(deferred_step),
    .inc_val (inc_val),
    .dec_val (dec_val)
  );

  ea_mem_req #(.AW(DW)) u_mreq (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .issue_addr(issue_addr),
    .mem_valid (mem_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .fire      (fire)
  );

  // Memory read launch points
  always_comb begin
    issue      = 1'b0;
    issue_addr = rf_rd_data;
    case (state)
      S_REGRD: begin
        if (mode_q == M_AINCDEF) begin
          issue = 1'b1;
          issue_addr = rf_rd_data;
        end else if (mode_q == M_ADECDEF) begin
          issue = 1'b1;
          issue_addr = dec_val;
        end
      end
      S_PCRD: begin
        issue = 1'b1;
        issue_addr = rf_rd_data;
      end
      S_IDX: begin
        if (mode_q == M_IDXDEF) begin
          issue = 1'b1;
          issue_addr = idx_sum;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mode_q     <= '0;
      reg_q      <= '0;
      byte_q     <= 1'b0;
      base_q     <= '0;
      done       <= 1'b0;
      is_reg     <= 1'b0;
      ea         <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
    end else begin
      done     <= 1'b0;
      rf_wr_en <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            mode_q <= spec_mode;
            reg_q  <= spec_reg;
            byte_q <= byte_op;
            is_reg <= 1'b0;
            state  <= S_REGRD;
          end
        end
        S_REGRD: begin
          rf_wr_idx <= reg_q;
          case (mode_q)
            M_REG: begin
              is_reg <= 1'b1;
              ea     <= '0;
              done   <= 1'b1;
              state  <= S_IDLE;
            end
            M_REGDEF: begin
              ea    <= rf_rd_data;
              done  <= 1'b1;
              state <= S_IDLE;
            end
            M_AINC: begin
              ea         <= rf_rd_data;
              rf_wr_en   <= 1'b1;
              rf_wr_data <= inc_val;
              done       <= 1'b1;
              state      <= S_IDLE;
            end
            M_AINCDEF: begin
              rf_wr_en   <= 1'b1;
              rf_wr_data <= inc_val;
              state      <= S_IND;
            end
            M_ADEC: begin
              ea         <= dec_val;
              rf_wr_en   <= 1'b1;
              rf_wr_data <= dec_val;
              done       <= 1'b1;
              state      <= S_IDLE;
            end
            M_ADECDEF: begin
              rf_wr_en   <= 1'b1;
              rf_wr_data <= dec_val;
              state      <= S_IND;
            end
            default: state <= S_PCRD;
          endcase
        end
        S_PCRD: begin
          rf_wr_en   <= 1'b1;
          rf_wr_idx  <= PC_SEL;
          rf_wr_data <= pc_next;
          state      <= S_BASE;
        end
        S_BASE: begin
          if (fire) begin
            base_q <= mem_rdata;
            state  <= S_IDX;
          end
        end
        S_IDX: begin
          if (mode_q == M_IDX) begin
            ea    <= idx_sum;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_IND;
          end
        end
        S_IND: begin
          if (fire) begin
            ea    <= mem_rdata;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_seq_checker.sv
module ea_seq_checker #(
  parameter int DW = 16,
  parameter int RW = 3,
  parameter int PC_IDX = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          is_reg,
  input logic [DW-1:0] ea,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [DW-1:0] mem_addr,
  input logic          rf_wr_en,
  input logic [RW-1:0] rf_wr_idx,
  input logic [DW-1:0] rf_wr_data
);
  // R9: pending request keeps its address until accepted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R11: completion lasts exactly one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: register operand has no side effects
  p_reg_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (done && is_reg) |-> (!rf_wr_en && !mem_req && ea == '0));

  // R1: program counter advanced past the word being fetched
  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (rf_wr_en && rf_wr_idx == RW'(PC_IDX) && mem_req && rf_wr_data != mem_addr)
      |-> (rf_wr_data == mem_addr + DW'(2)));

  // R1: immediate through register 7 reports old PC and advances it by two
  p_imm_step_r1: assert property (@(posedge clk) disable iff (rst)
    (done && rf_wr_en && rf_wr_idx == RW'(PC_IDX) && rf_wr_data != ea)
      |-> (rf_wr_data == ea + DW'(2)));

  // R9: no request is left open when an operation completes
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
endmodule

bind oprnd_ea_seq ea_seq_checker #(.DW(DW), .RW(RW), .PC_IDX(PC_IDX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .is_reg    (is_reg),
  .ea        (ea),
  .mem_req   (mem_req),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr),
  .rf_wr_en  (rf_wr_en),
  .rf_wr_idx (rf_wr_idx),
  .rf_wr_data(rf_wr_data)
);

// File: tb/test_oprnd_ea_seq.sv
module test_oprnd_ea_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  spec_mode;
  logic [2:0]  spec_reg;
  logic        byte_op;
  logic        done, is_reg;
  logic [15:0] ea;
  logic [2:0]  rf_rd_idx;
  logic [15:0] rf_rd_data;
  logic        rf_wr_en;
  logic [2:0]  rf_wr_idx;
  logic [15:0] rf_wr_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid;
  logic [15:0] mem_rdata;

  always #5 clk = ~clk;

  oprnd_ea_seq i_oprnd_ea_seq (
    .clk(clk), .rst(rst), .start(start), .spec_mode(spec_mode),
    .spec_reg(spec_reg), .byte_op(byte_op), .done(done), .is_reg(is_reg),
    .ea(ea), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata)
  );

  logic [15:0] regs [8];
  logic [15:0] exp_regs [8];
  logic [15:0] mem_ovr [logic [15:0]];
  logic [15:0] exp_addr_q [$];
  int n_cmp = 0;
  int n_bad = 0;
  int lat = 0;
  int wait_cnt = 0;
  bit finished = 0;

  function automatic logic [15:0] mem_val(logic [15:0] a);
    if (mem_ovr.exists(a)) return mem_ovr[a];
    return a * 16'd3 + 16'h1357;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // External register file
  assign rf_rd_data = regs[rf_rd_idx];
  always @(posedge clk) if (rf_wr_en) regs[rf_wr_idx] <= rf_wr_data;

  // Memory responder with configurable latency; checks each read address (R12)
  always @(negedge clk) begin
    if (rst || !mem_req) begin
      mem_valid = 1'b0;
      wait_cnt  = 0;
    end else if (!mem_valid) begin
      if (wait_cnt >= lat) begin
        mem_valid = 1'b1;
        mem_rdata = mem_val(mem_addr);
        if (exp_addr_q.size() == 0) begin
          chk("R12 unexpected read", mem_addr, 16'hxxxx);
        end else begin
          chk("R12 read address", mem_addr, exp_addr_q.pop_front());
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic set_reg(int i, logic [15:0] v);
    regs[i] = v;
    exp_regs[i] = v;
  endtask

  task automatic run_op(logic [2:0] m, logic [2:0] r, logic b, string tag);
    logic [15:0] v, st, nv, pc, base, a, exp_ea;
    bit exp_isreg;
    int cnt;
    exp_isreg = 0;
    exp_ea = '0;
    v  = exp_regs[r];
    st = (b && r < 6) ? 16'd1 : 16'd2;
    case (m)
      3'd0: exp_isreg = 1;
      3'd1: exp_ea = v;
      3'd2: begin exp_ea = v; exp_regs[r] = v + st; end
      3'd3: begin exp_addr_q.push_back(v); exp_regs[r] = v + 16'd2; exp_ea = mem_val(v); end
      3'd4: begin nv = v - st; exp_regs[r] = nv; exp_ea = nv; end
      3'd5: begin nv = v - 16'd2; exp_regs[r] = nv; exp_addr_q.push_back(nv); exp_ea = mem_val(nv); end
      default: begin
        pc = exp_regs[7];
        exp_addr_q.push_back(pc);
        base = mem_val(pc);
        exp_regs[7] = pc + 16'd2;
        a = base + exp_regs[r];
        if (m == 3'd6) exp_ea = a;
        else begin exp_addr_q.push_back(a); exp_ea = mem_val(a); end
      end
    endcase
    @(negedge clk);
    spec_mode = m; spec_reg = r; byte_op = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 50) begin @(negedge clk); cnt++; end
    if (!done) begin
      chk({tag, " R11 done timeout"}, 16'd0, 16'd1);
      return;
    end
    chk({tag, " is_reg"}, {15'd0, is_reg}, {15'd0, exp_isreg});
    chk({tag, " ea"}, ea, exp_ea);
    @(negedge clk);
    chk({tag, " R11 done pulse"}, {15'd0, done}, 16'd0);
    for (int i = 0; i < 8; i++) chk({tag, $sformatf(" reg%0d", i)}, regs[i], exp_regs[i]);
    chk({tag, " R12 reads left"}, 16'(exp_addr_q.size()), 16'd0);
    exp_addr_q.delete();
  endtask

  initial begin
    #2_000_000;
    chk("watchdog", 16'd0, 16'd1);
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0; spec_mode = '0; spec_reg = '0; byte_op = 1'b0;
    mem_valid = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 8; i++) set_reg(i, 16'h1000 + 16'(i) * 16'h0110);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 done at reset", {15'd0, done}, 16'd0);
    chk("R11 mem_req at reset", {15'd0, mem_req}, 16'd0);
    chk("R11 rf_wr_en at reset", {15'd0, rf_wr_en}, 16'd0);
    rst = 1'b0;
    @(negedge clk);

    // R7: PC-relative worked example
    set_reg(7, 16'o22);
    mem_ovr[16'o22] = 16'o54;
    run_op(3'd6, 3'd7, 1'b0, "R7 relative");
    chk("R7 relative ea octal 100", ea, 16'o100);

    // R8: index deferred worked example
    set_reg(4, 16'o100);
    set_reg(7, 16'o500);
    mem_ovr[16'o500] = 16'o14;
    mem_ovr[16'o114] = 16'o2000;
    run_op(3'd7, 3'd4, 1'b0, "R8 index deferred");
    chk("R8 ea octal 2000", ea, 16'o2000);

    // R2, R3 basics
    run_op(3'd0, 3'd2, 1'b0, "R2 register");
    run_op(3'd1, 3'd3, 1'b1, "R3 deferred register");

    // R4: byte step 1 on r3, 2 on r6 and r7 (immediate)
    run_op(3'd2, 3'd3, 1'b1, "R4 byte inc r3");
    run_op(3'd2, 3'd6, 1'b1, "R4 byte inc r6");
    run_op(3'd2, 3'd7, 1'b1, "R4 R1 immediate r7");
    // R5: decrement, byte and word
    run_op(3'd4, 3'd1, 1'b1, "R5 byte dec r1");
    run_op(3'd4, 3'd5, 1'b0, "R5 word dec r5");
    // R6: deferred step is 2 even for byte, absolute through r7
    run_op(3'd3, 3'd2, 1'b1, "R6 inc deferred byte");
    run_op(3'd5, 3'd0, 1'b1, "R6 dec deferred byte");
    run_op(3'd3, 3'd7, 1'b0, "R6 R1 absolute r7");

    // R10: wraparound
    set_reg(1, 16'h0000);
    run_op(3'd4, 3'd1, 1'b0, "R10 dec wrap");
    set_reg(2, 16'hFFFF);
    run_op(3'd2, 3'd2, 1'b1, "R10 inc wrap");
    set_reg(7, 16'hFFFE);
    run_op(3'd6, 3'd5, 1'b0, "R10 R1 pc wrap");

    // R9, R12: full sweep under latencies 0..2
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int m = 0; m < 8; m++) begin
        for (int r = 0; r < 8; r++) begin
          for (int b = 0; b < 2; b++) begin
            set_reg(r, 16'(m * 16'h1111 + r * 16'h0203 + l * 16'h4000 + b));
            if (r != 7) set_reg(7, 16'(16'h2000 + m * 16'h0040 + l * 16'h0100));
            run_op(3'(m), 3'(r), b[0], $sformatf("R9 sweep m%0d r%0d b%0d l%0d", m, r, b, l));
          end
        end
      end
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule